// File: doc/BRIEF.md
# LPC Firmware-Read Host Initiator

This block is the host side of a single-byte firmware memory read on a four-bit multiplexed LAD bus with an active-low frame strobe. A client hands over a target select nibble and a 28-bit byte address through a valid/ready handshake. The block then serialises the request onto the bus, one nibble per clock, in this order: start code, select, address, size code and the first turnaround clock.

After that the block stops driving LAD and listens. It waits for the target's ready sync nibble, reassembles the returned byte (low nibble first), and lets the target hand the bus back over two turnaround clocks. It then reports the byte with a one-cycle completion pulse. If the target never signals ready within a bounded number of clocks, the block ends the cycle with an error flag instead.

Top module: `lfr_host`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `lframe_n` is 1, `lad_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: In the clock after a request is accepted (`req_valid` and `req_ready` high at a rising edge), `lframe_n` is 0, `lad_oe` is 1 and `lad_out` is 4'b1101. `lframe_n` is 1 in every other clock.
- R3: In the next clock the block drives the request's select nibble on `lad_out` with `lad_oe` high.
- R4: Over the following seven clocks the block drives the address nibbles, bits [27:24] first and bits [3:0] last.
- R5: The block then drives 4'b0000 for one clock (single-byte size) and 4'b1111 for one clock. From the next clock it holds `lad_oe` at 0 until the next request.
- R6: From the second clock after the 4'b1111 clock, each clock is a sync clock. A `lad_in` value other than 4'b0000 extends the wait. The value 4'b0000 marks ready; the next two `lad_in` nibbles are data bits [3:0] and then bits [7:4].
- R7: After the high data nibble, two further turnaround clocks pass. Then `rsp_done` is high for one clock with `rsp_err` 0 and `rsp_data` equal to the assembled byte.
- R8: If `TMO_CYC` consecutive sync clocks pass without 4'b0000, the next clock shows `rsp_done` 1, `rsp_err` 1, `rsp_data` 0 and `req_ready` 1. With `TMO_CYC`-1 non-ready clocks followed by ready, the read completes normally.
- R9: `req_ready` is 0 from the clock after acceptance through the final turnaround clock. It is 1 again in the clock where `rsp_done` is high.
- R10: `rsp_done` never stays high for two consecutive clocks, and `rsp_err` is high only together with `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_idsel | input | 4 | Target select nibble |
| req_addr | input | 28 | Byte address |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended by sync timeout |
| rsp_data | output | 8 | Byte returned by the target |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_out | output | 4 | Nibble driven onto LAD |
| lad_oe | output | 1 | LAD output enable |
| lad_in | input | 4 | Nibble sampled from LAD |

## Verification
On every cycle the assertions check the following: the frame strobe pairs with the start code and lasts one clock; acceptance is followed by the strobe and by a busy handshake; completion is a single pulse that coincides with the ready handshake and carries any error. Only the bench scenarios can show the full content of the nibble stream. That covers the select and address order, the size and turnaround codes, and where the bus is released. The same holds for byte reassembly under different wait lengths, and for the exact boundary between the last permitted wait clock and the timeout.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] CODE_START = 4'b1101;
    localparam logic [NIB_W-1:0] CODE_SIZE1 = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_RDY   = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_TURN  = 4'b1111;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_SEL,
        PH_ADDR,
        PH_SIZE,
        PH_HTURN0,
        PH_HTURN1,
        PH_SYNC,
        PH_DLO,
        PH_DHI,
        PH_TTURN0,
        PH_TTURN1
    } phase_e;

    // phases in which the host owns LAD
    function automatic logic host_drives(input phase_e ph);
        return (ph == PH_START) || (ph == PH_SEL) || (ph == PH_ADDR) ||
               (ph == PH_SIZE)  || (ph == PH_HTURN0);
    endfunction

endpackage

// File: rtl/lfr_seq.sv
module lfr_seq
    import lfr_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int TMO_CYC   = 16,
    localparam int IDX_W    = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1,
    localparam int CNT_W    = $clog2(TMO_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic [NIB_W-1:0] lad_in,
    output phase_e           phase,
    output logic [IDX_W-1:0] nib_idx,
    output logic             timeout
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    phase_e           ph_q, ph_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rdy_seen;

    assign rdy_seen = (lad_in == CODE_RDY);
    assign timeout  = (ph_q == PH_SYNC) && !rdy_seen && (cnt_q == CNT_LAST);

    always_comb begin
        ph_d  = ph_q;
        idx_d = idx_q;
        cnt_d = cnt_q;
        unique case (ph_q)
            PH_IDLE:   if (req_fire) ph_d = PH_START;
            PH_START:  ph_d = PH_SEL;
            PH_SEL: begin
                ph_d  = PH_ADDR;
                idx_d = '0;
            end
            PH_ADDR: begin
                if (idx_q == IDX_LAST) ph_d = PH_SIZE;
                else                   idx_d = idx_q + 1'b1;
            end
            PH_SIZE:   ph_d = PH_HTURN0;
            PH_HTURN0: ph_d = PH_HTURN1;
            PH_HTURN1: begin
                ph_d  = PH_SYNC;
                cnt_d = '0;
            end
            PH_SYNC: begin
                if (rdy_seen)     ph_d = PH_DLO;
                else if (timeout) ph_d = PH_IDLE;
                else              cnt_d = cnt_q + 1'b1;
            end
            PH_DLO:    ph_d = PH_DHI;
            PH_DHI:    ph_d = PH_TTURN0;
            PH_TTURN0: ph_d = PH_TTURN1;
            PH_TTURN1: ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            idx_q <= idx_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase   = ph_q;
    assign nib_idx = idx_q;

endmodule

// File: rtl/lfr_drv.sv
module lfr_drv
    import lfr_pkg::*;
#(
    parameter int ADDR_W    = 28,
    localparam int ADDR_NIBS = ADDR_W / NIB_W,
    localparam int IDX_W    = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_fire,
    input  logic [NIB_W-1:0]  req_idsel,
    input  logic [ADDR_W-1:0] req_addr,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  nib_idx,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe,
    output logic              lframe_n
);

    typedef struct packed {
        logic [NIB_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
    } req_t;

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ADDR_NIBS - 1);

    req_t             req_q;
    logic [NIB_W-1:0] addr_nib [ADDR_NIBS];
    logic [IDX_W-1:0] pick;

    always_ff @(posedge clk) begin
        if (rst)           req_q <= '0;
        else if (req_fire) req_q <= '{sel: req_idsel, addr: req_addr};
    end

    for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
        assign addr_nib[g] = req_q.addr[g*NIB_W +: NIB_W];
    end

    // most-significant nibble leaves first
    assign pick = IDX_TOP - nib_idx;

    always_comb begin
        unique case (phase)
            PH_START:  lad_out = CODE_START;
            PH_SEL:    lad_out = req_q.sel;
            PH_ADDR:   lad_out = addr_nib[pick];
            PH_SIZE:   lad_out = CODE_SIZE1;
            default:   lad_out = CODE_TURN;
        endcase
    end

    assign lad_oe   = host_drives(phase);
    assign lframe_n = (phase != PH_START);

endmodule

// File: rtl/lfr_rsp.sv
module lfr_rsp
    import lfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             timeout,
    input  logic [NIB_W-1:0] lad_in,
    output logic             done,
    output logic             err,
    output logic [7:0]       data
);

    logic [NIB_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (phase == PH_DLO) lo_q <= lad_in;
            if (phase == PH_DHI) hi_q <= lad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            err  <= 1'b0;
            data <= '0;
        end else if (timeout) begin
            done <= 1'b1;
            err  <= 1'b1;
            data <= '0;
        end else if (phase == PH_TTURN1) begin
            done <= 1'b1;
            err  <= 1'b0;
            data <= {hi_q, lo_q};
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
        end
    end

endmodule

// File: rtl/lfr_host.sv
module lfr_host
    import lfr_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int TMO_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_idsel,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [7:0]        rsp_data,
    output logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        lad_in
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int IDX_W     = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

    phase_e           phase;
    logic [IDX_W-1:0] nib_idx;
    logic             timeout;
    logic             req_fire;

    assign req_ready = (phase == PH_IDLE);
    assign req_fire  = req_valid && req_ready;

    lfr_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .TMO_CYC   (TMO_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_fire (req_fire),
        .lad_in   (lad_in),
        .phase    (phase),
        .nib_idx  (nib_idx),
        .timeout  (timeout)
    );

    lfr_drv #(
        .ADDR_W (ADDR_W)
    ) u_drv (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_idsel (req_idsel),
        .req_addr  (req_addr),
        .phase     (phase),
        .nib_idx   (nib_idx),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .lframe_n  (lframe_n)
    );

    lfr_rsp u_rsp (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .timeout (timeout),
        .lad_in  (lad_in),
        .done    (rsp_done),
        .err     (rsp_err),
        .data    (rsp_data)
    );

endmodule

// File: rtl/lfr_host_chk.sv
module lfr_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       rsp_err,
    input logic       lframe_n,
    input logic [3:0] lad_out,
    input logic       lad_oe
);

    a_r2_strobe_carries_start: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |-> (lad_oe && lad_out == 4'b1101));

    a_r2_strobe_one_clock: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |=> lframe_n);

    a_r2_accept_then_strobe: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !lframe_n);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_done_when_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

    a_r5_released_when_done: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !lad_oe);

endmodule

bind lfr_host lfr_host_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .lframe_n  (lframe_n),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe)
);

// File: tb/sim_lfr_host.sv
`timescale 1ns/1ps
module sim_lfr_host;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_idsel = '0;
    logic [27:0] req_addr = '0;
    logic        rsp_done, rsp_err;
    logic [7:0]  rsp_data;
    logic        lframe_n, lad_oe;
    logic [3:0]  lad_out;
    logic [3:0]  lad_in = 4'b1111;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lfr_host #(.ADDR_W(28), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_idsel(req_idsel), .req_addr(req_addr), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .lframe_n(lframe_n),
        .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
    );

    // {idsel, addr, data, wait clocks}
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {4'h0, 28'h0000000, 8'h00, 8'd0},
        {4'hA, 28'hFFFFFFF, 8'hFF, 8'd1},
        {4'h3, 28'h1234567, 8'h5A, 8'd2},
        {4'hF, 28'h89ABCDE, 8'hC3, 8'd0},
        {4'h7, 28'hF0F0F0F, 8'h81, 8'd5},
        {4'h1, 28'h0EDCBA9, 8'h3C, 8'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    // one read; nwait non-ready sync clocks before ready (>= TMO means timeout)
    task automatic run_txn(input logic [3:0] sel, input logic [27:0] addr,
                           input logic [7:0] dat, input int nwait);
        logic [3:0] exp_nib;
        bit to;
        to = (nwait >= TMO);
        @(negedge clk);
        req_valid = 1'b1;
        req_idsel = sel;
        req_addr  = addr;
        chk(req_ready, "R9 idle ready", req_ready, 1);
        @(posedge clk);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                chk(!req_ready, "R9 busy after accept", req_ready, 0);
            end
            if (k == 1)       exp_nib = 4'b1101;
            else if (k == 2)  exp_nib = sel;
            else if (k <= 9)  exp_nib = 4'((addr >> (4 * (9 - k))) & 28'hF);
            else if (k == 10) exp_nib = 4'b0000;
            else              exp_nib = 4'b1111;
            chk(lad_out == exp_nib,
                k == 1 ? "R2 start nibble" : k == 2 ? "R3 select nibble" :
                k <= 9 ? "R4 address nibble" : "R5 size/turn nibble",
                lad_out, exp_nib);
            chk(lad_oe, "R5 host drives", lad_oe, 1);
            chk(lframe_n == (k != 1), "R2 frame strobe", lframe_n, k != 1);
        end
        @(negedge clk);
        lad_in = 4'b1111;
        chk(!lad_oe, "R5 release", lad_oe, 0);
        chk(lframe_n, "R2 strobe high", lframe_n, 1);
        for (int w = 0; w < nwait && w < TMO; w++) begin
            @(negedge clk);
            lad_in = (w % 2 == 0) ? 4'b0110 : 4'b1111;
            chk(!lad_oe && !rsp_done, "R6 waiting", {lad_oe, rsp_done}, 0);
        end
        if (to) begin
            @(negedge clk);
            lad_in = 4'b1111;
            chk(rsp_done && rsp_err, "R8 timeout done+err", {rsp_done, rsp_err}, 3);
            chk(rsp_data == 8'h00, "R8 timeout data", rsp_data, 0);
            chk(req_ready, "R8 idle after timeout", req_ready, 1);
        end else begin
            @(negedge clk); lad_in = 4'b0000;
            @(negedge clk); lad_in = dat[3:0];
            @(negedge clk); lad_in = dat[7:4];
            @(negedge clk); lad_in = 4'b1111;
            chk(!lad_oe, "R7 target turnaround", lad_oe, 0);
            @(negedge clk); lad_in = 4'b1111;
            chk(!req_ready && !rsp_done, "R9 busy in last turnaround",
                {req_ready, rsp_done}, 0);
            @(negedge clk);
            chk(rsp_done && !rsp_err, "R7 done no err", {rsp_done, rsp_err}, 2);
            chk(rsp_data == dat, "R6 assembled byte", rsp_data, dat);
            chk(req_ready, "R9 ready with done", req_ready, 1);
            @(negedge clk);
            chk(!rsp_done, "R10 single pulse", rsp_done, 0);
        end
        @(negedge clk);
        chk(!rsp_done && lframe_n && !lad_oe, "R10 quiet idle",
            {rsp_done, lframe_n, lad_oe}, 3'b010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(lframe_n && !lad_oe && req_ready && !rsp_done, "R1 in reset",
            {lframe_n, lad_oe, req_ready, rsp_done}, 4'b1010);
        rst = 1'b0;
        @(negedge clk);
        chk(lframe_n && !lad_oe && req_ready && !rsp_done, "R1 after reset",
            {lframe_n, lad_oe, req_ready, rsp_done}, 4'b1010);

        for (int i = 0; i < NV; i++)
            run_txn(VEC[i][47:44], VEC[i][43:16], VEC[i][15:8], int'(VEC[i][7:0]));

        // R8 boundary: last permitted wait clock, then exact timeout
        run_txn(4'h9, 28'h2468ACE, 8'hE7, TMO - 1);
        run_txn(4'h2, 28'h1357BDF, 8'h11, TMO);
        // recovery after timeout
        run_txn(4'h4, 28'h0000001, 8'h96, 0);

        // R1: reset mid-frame returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_idsel = 4'h5; req_addr = 28'h5555555;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(lframe_n && !lad_oe && req_ready, "R1 reset mid-frame",
            {lframe_n, lad_oe, req_ready}, 3'b101);
        run_txn(4'hB, 28'hABCDEF0, 8'h42, 1);

        summary();
    end

endmodule